// File: doc/BRIEF.md
# Buck Start-up and Protection Sequencer

This block is the digital supervisor for a synchronous step-down gate-drive stage. It takes digital flags from the analog side: an enable, undervoltage on several supply rails, bootstrap undervoltage, over-temperature, a flag that the timing capacitor has finished charging, the low-side gate feedback, a hiccup request and a hiccup-done flag. It also takes the raw PWM decision and a pulse at the start of each switching cycle. From these it produces registered high-side and low-side gate enables, a soft-start reset and a sticky shutdown flag.

Start-up runs in a fixed order. The block first waits for the timing capacitor. It then spends at least one switching cycle in bootstrap precharge, where the low-side gate gets one short fixed pulse per cycle. Only after that does it enter run mode, where it follows the PWM decision. In run mode it enforces dead time on both sides of the low-side pulse and a minimum low-side pulse. Together these set a minimum high-side off time. The synchronous rectifier stays off until the high side has switched once, so a pre-biased output is never discharged. In every cycle where the low side is driven, its feedback is checked once the minimum pulse has elapsed. If the feedback is missing, the block latches off.

All timings are given in clock ticks as parameters. With `DT_TICKS`=D, `LS_MIN_TICKS`=M and `PC_TICKS`=P, the minimum high-side off time is 2D+M ticks.

Top module: `buck_startup_sequencer`

## Requirements
- R1: When `en` is sampled low, the next clock edge leaves `hs_on`=0, `ls_on`=0, `ss_reset`=1 and `latched_off`=0. Synchronous reset gives the same state.
- R2: When any bit of `uv_rail` or `ot_flag` is sampled high while `en`=1, the next edge drives both gates off and sets `ss_reset`=1. After every flag clears, the block restarts by itself through the capacitor wait and precharge, with no need to cycle `en`.
- R3: After start-up or a rail or over-temperature fault, the block does not enter precharge while `tcap_ready` is low. No low-side pulse is issued, and `ss_reset` stays 1. The edge that samples `tcap_ready`=1 enters precharge.
- R4: In precharge, `hs_on` stays 0 and `ss_reset` stays 1. A `cycle_start` sampled at edge e gives `ls_on`=1 after edges e+D through e+D+P-1, and 0 otherwise.
- R5: Precharge hands over to run mode at an edge that samples `cycle_start`=1 and `uv_boot`=0. `ss_reset` goes to 0 after that edge.
- R6: When `uv_boot` is sampled high, `hs_on` is 0 after the next edge and `ss_reset` is 1. The block is then in precharge (see R4).
- R7: In run mode or precharge, a sampled `hiccup_req` turns both gates off and sets `ss_reset`=1 at the next edge. This holds until `hiccup_done` is sampled, after which the block enters precharge.
- R8: In run mode, if `pwm` is sampled low at edge e and high from edge e+L on, then `hs_on`=0 after e. Let X = max(D+M, L). `ls_on`=1 after edges e+D to e+X-1, and `hs_on` returns to 1 after edge e+X+D.
- R9: After entering run mode, `ls_on` stays 0 until `hs_on` has been 1 at least once. With `pwm` held high, the first `hs_on` appears after edge e0+2D+M, where e0 is the hand-over edge.
- R10: If `ls_fb` is sampled low while the low side is driven and its minimum window (run mode) or precharge pulse has reached its last tick, the next edge sets `latched_off`=1 and turns both gates off. This state holds, whatever the other inputs do, until `en` goes low or reset is applied.
- R11: `hs_on` and `ls_on` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Converter enable; low means standby |
| uv_rail | input | N_RAILS | Undervoltage flags, one per supply rail |
| ot_flag | input | 1 | Over-temperature flag |
| uv_boot | input | 1 | Bootstrap capacitor undervoltage flag |
| tcap_ready | input | 1 | Timing capacitor has reached its precharge threshold |
| cycle_start | input | 1 | One-clock pulse at the start of each switching cycle |
| pwm | input | 1 | PWM decision: high asks for the high side |
| ls_fb | input | 1 | Feedback that the low-side gate is actually high |
| hiccup_req | input | 1 | Request to enter hiccup shutdown |
| hiccup_done | input | 1 | Hiccup hold time has expired |
| hs_on | output | 1 | High-side gate enable (registered) |
| ls_on | output | 1 | Low-side gate enable (registered) |
| ss_reset | output | 1 | Holds soft-start and feedback nodes in reset |
| latched_off | output | 1 | Sticky shutdown after a low-side gate short |

## Verification
The assertions assume that all flags are already synchronous to `clk`. They also assume that `cycle_start` pulses are spaced more than D+P+1 clocks apart, and that `ls_fb` follows `ls_on` within less than the minimum low-side window. The stimulus changes every input only on falling clock edges. It models the gate feedback as `ls_on` delayed by half a clock, unless a short is injected on purpose. It waits at least D+P+2 clocks between switching-cycle pulses. The PWM sweep runs every low time from one clock up to past the full minimum off window, so both the stretched and the pass-through low-side cases appear.

// File: rtl/bss_pkg.sv
package bss_pkg;

  typedef enum logic [2:0] {
    MD_OFF,
    MD_FAULT,
    MD_WAIT,
    MD_PRECHG,
    MD_RUN,
    MD_HICCUP,
    MD_LATCH
  } seq_state_t;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_HS,
    PH_DT_LO,
    PH_LS,
    PH_DT_HI,
    PH_PC_DT,
    PH_PC
  } gate_phase_t;

endpackage

// File: rtl/bss_mode_fsm.sv
module bss_mode_fsm
  import bss_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       rail_fault,
  input  logic       uv_boot,
  input  logic       tcap_ready,
  input  logic       cycle_start,
  input  logic       hiccup_req,
  input  logic       hiccup_done,
  input  logic       ls_trip,
  output seq_state_t st_q,
  output seq_state_t st_nx,
  output logic       ss_reset,
  output logic       latched_off
);

  // Priority: standby, latched short, rail or thermal fault, then the
  // normal sequence.
  always_comb begin
    st_nx = st_q;
    if (!en) begin
      st_nx = MD_OFF;
    end else if (st_q == MD_LATCH || ls_trip) begin
      st_nx = MD_LATCH;
    end else if (rail_fault) begin
      st_nx = MD_FAULT;
    end else begin
      case (st_q)
        MD_OFF, MD_FAULT: st_nx = MD_WAIT;
        MD_WAIT:          if (tcap_ready) st_nx = MD_PRECHG;
        MD_PRECHG: begin
          if (hiccup_req)                     st_nx = MD_HICCUP;
          else if (cycle_start && !uv_boot)   st_nx = MD_RUN;
        end
        MD_RUN: begin
          if (hiccup_req)   st_nx = MD_HICCUP;
          else if (uv_boot) st_nx = MD_PRECHG;
        end
        MD_HICCUP:        if (hiccup_done) st_nx = MD_PRECHG;
        default:          st_nx = MD_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= MD_OFF;
      ss_reset    <= 1'b1;
      latched_off <= 1'b0;
    end else begin
      st_q        <= st_nx;
      ss_reset    <= (st_nx != MD_RUN);
      latched_off <= (st_nx == MD_LATCH);
    end
  end

  // R10
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (latched_off && en) |=> latched_off);

  // R5
  ss_run_chk: assert property (@(posedge clk) disable iff (rst)
    !ss_reset |-> st_q == MD_RUN);

endmodule

// File: rtl/bss_gate_timer.sv
module bss_gate_timer
  import bss_pkg::*;
#(
  parameter int DT_TICKS     = 10,
  parameter int LS_MIN_TICKS = 10,
  parameter int PC_TICKS     = 30
) (
  input  logic clk,
  input  logic rst,
  input  logic run_en,
  input  logic pc_en,
  input  logic pwm,
  input  logic cycle_start,
  input  logic ls_fb,
  output logic hs_on,
  output logic ls_on,
  output logic ls_trip
);

  localparam int CNT_MAX_A = (DT_TICKS > LS_MIN_TICKS) ? DT_TICKS : LS_MIN_TICKS;
  localparam int CNT_MAX   = (CNT_MAX_A > PC_TICKS) ? CNT_MAX_A : PC_TICKS;
  localparam int CNT_W     = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] DT_LAST = CNT_W'(DT_TICKS - 1);
  localparam logic [CNT_W-1:0] LS_LAST = CNT_W'(LS_MIN_TICKS - 1);
  localparam logic [CNT_W-1:0] PC_LAST = CNT_W'(PC_TICKS - 1);
  localparam int MIN_OFF = 2 * DT_TICKS + LS_MIN_TICKS;
  localparam int OFF_W   = $clog2(MIN_OFF + 1);
  localparam logic [OFF_W-1:0] OFF_SAT = OFF_W'(MIN_OFF);

  gate_phase_t      phase, ph_nx;
  logic [CNT_W-1:0] cnt, cnt_nx;
  logic             hs_seen, hs_seen_nx;
  logic             fb_strobe;

  always_comb begin
    ph_nx  = phase;
    cnt_nx = cnt;
    if (run_en) begin
      case (phase)
        PH_HS: begin
          if (!pwm) begin ph_nx = PH_DT_LO; cnt_nx = '0; end
        end
        PH_DT_LO: begin
          if (cnt == DT_LAST) begin ph_nx = PH_LS; cnt_nx = '0; end
          else cnt_nx = cnt + 1'b1;
        end
        PH_LS: begin
          if (cnt >= LS_LAST) begin
            if (pwm) begin ph_nx = PH_DT_HI; cnt_nx = '0; end
          end else begin
            cnt_nx = cnt + 1'b1;
          end
        end
        PH_DT_HI: begin
          if (cnt == DT_LAST) begin
            ph_nx  = pwm ? PH_HS : PH_DT_LO;
            cnt_nx = '0;
          end else begin
            cnt_nx = cnt + 1'b1;
          end
        end
        default: begin ph_nx = PH_DT_LO; cnt_nx = '0; end
      endcase
    end else if (pc_en) begin
      case (phase)
        PH_IDLE: begin
          if (cycle_start) begin ph_nx = PH_PC_DT; cnt_nx = '0; end
        end
        PH_PC_DT: begin
          if (cnt == DT_LAST) begin ph_nx = PH_PC; cnt_nx = '0; end
          else cnt_nx = cnt + 1'b1;
        end
        PH_PC: begin
          if (cnt == PC_LAST) begin ph_nx = PH_IDLE; cnt_nx = '0; end
          else cnt_nx = cnt + 1'b1;
        end
        default: begin ph_nx = PH_IDLE; cnt_nx = '0; end
      endcase
    end else begin
      ph_nx  = PH_IDLE;
      cnt_nx = '0;
    end
  end

  assign hs_seen_nx = run_en && (hs_seen || ph_nx == PH_HS);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      hs_seen <= 1'b0;
      hs_on   <= 1'b0;
      ls_on   <= 1'b0;
    end else begin
      phase   <= ph_nx;
      cnt     <= cnt_nx;
      hs_seen <= hs_seen_nx;
      hs_on   <= (ph_nx == PH_HS);
      ls_on   <= (ph_nx == PH_LS && hs_seen_nx) || (ph_nx == PH_PC);
    end
  end

  // Feedback is judged once the driven pulse reaches its last minimum tick.
  assign fb_strobe = ls_on && ((phase == PH_LS && cnt == LS_LAST) ||
                               (phase == PH_PC && cnt == PC_LAST));
  assign ls_trip   = fb_strobe && !ls_fb;

  // Observation counter: consecutive cycles with the high side off.
  logic [OFF_W-1:0] off_run;
  always_ff @(posedge clk) begin
    if (rst)                   off_run <= OFF_SAT;
    else if (hs_on)            off_run <= '0;
    else if (off_run != OFF_SAT) off_run <= off_run + 1'b1;
  end

  // R11
  gate_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(hs_on && ls_on));

  // R8
  min_off_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_on) |-> off_run >= OFF_SAT);

  // R8
  dead_before_ls_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ls_on) |-> !$past(hs_on));

  // R8
  dead_after_ls_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ls_on) |-> !hs_on);

endmodule

// File: rtl/buck_startup_sequencer.sv
module buck_startup_sequencer
  import bss_pkg::*;
#(
  parameter int N_RAILS      = 3,
  parameter int DT_TICKS     = 10,
  parameter int LS_MIN_TICKS = 10,
  parameter int PC_TICKS     = 30
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic [N_RAILS-1:0] uv_rail,
  input  logic               ot_flag,
  input  logic               uv_boot,
  input  logic               tcap_ready,
  input  logic               cycle_start,
  input  logic               pwm,
  input  logic               ls_fb,
  input  logic               hiccup_req,
  input  logic               hiccup_done,
  output logic               hs_on,
  output logic               ls_on,
  output logic               ss_reset,
  output logic               latched_off
);

  seq_state_t st_q, st_nx;
  logic       rail_fault;
  logic       ls_trip;

  assign rail_fault = (|uv_rail) || ot_flag;

  bss_mode_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .en          (en),
    .rail_fault  (rail_fault),
    .uv_boot     (uv_boot),
    .tcap_ready  (tcap_ready),
    .cycle_start (cycle_start),
    .hiccup_req  (hiccup_req),
    .hiccup_done (hiccup_done),
    .ls_trip     (ls_trip),
    .st_q        (st_q),
    .st_nx       (st_nx),
    .ss_reset    (ss_reset),
    .latched_off (latched_off)
  );

  bss_gate_timer #(
    .DT_TICKS     (DT_TICKS),
    .LS_MIN_TICKS (LS_MIN_TICKS),
    .PC_TICKS     (PC_TICKS)
  ) u_timer (
    .clk         (clk),
    .rst         (rst),
    .run_en      (st_nx == MD_RUN),
    .pc_en       (st_nx == MD_PRECHG),
    .pwm         (pwm),
    .cycle_start (cycle_start),
    .ls_fb       (ls_fb),
    .hs_on       (hs_on),
    .ls_on       (ls_on),
    .ls_trip     (ls_trip)
  );

  // R1
  standby_off_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!hs_on && !ls_on && ss_reset && !latched_off));

  // R2
  rail_fault_off_chk: assert property (@(posedge clk) disable iff (rst)
    (en && rail_fault) |=> (!hs_on && !ls_on && ss_reset));

  // R6
  boot_uv_hs_chk: assert property (@(posedge clk) disable iff (rst)
    uv_boot |=> !hs_on);

  // R4
  hs_only_run_chk: assert property (@(posedge clk) disable iff (rst)
    hs_on |-> st_q == MD_RUN);

endmodule

// File: tb/buck_startup_sequencer_tb.sv
module buck_startup_sequencer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NR = 3;
  localparam int D  = 2;
  localparam int M  = 3;
  localparam int P  = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          en = 1'b0;
  logic [NR-1:0] uv_rail = '0;
  logic          ot_flag = 1'b0;
  logic          uv_boot = 1'b1;
  logic          tcap_ready = 1'b0;
  logic          cycle_start = 1'b0;
  logic          pwm = 1'b0;
  logic          ls_fb = 1'b0;
  logic          hiccup_req = 1'b0;
  logic          hiccup_done = 1'b0;
  logic          hs_on, ls_on, ss_reset, latched_off;
  logic          short_inj = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  int overlap_cnt = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  buck_startup_sequencer #(
    .N_RAILS(NR), .DT_TICKS(D), .LS_MIN_TICKS(M), .PC_TICKS(P)
  ) u_dut (
    .clk(clk), .rst(rst), .en(en), .uv_rail(uv_rail), .ot_flag(ot_flag),
    .uv_boot(uv_boot), .tcap_ready(tcap_ready), .cycle_start(cycle_start),
    .pwm(pwm), .ls_fb(ls_fb), .hiccup_req(hiccup_req),
    .hiccup_done(hiccup_done), .hs_on(hs_on), .ls_on(ls_on),
    .ss_reset(ss_reset), .latched_off(latched_off)
  );

  // Gate feedback model: follows the low-side enable half a clock later.
  always @(negedge clk) begin
    ls_fb <= ls_on && !short_inj;
    if (!rst && hs_on && ls_on) overlap_cnt <= overlap_cnt + 1;
  end

  task automatic chk_eq(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  task automatic gates_off(input string req);
    chk_eq(req, "hs_on", hs_on, 0);
    chk_eq(req, "ls_on", ls_on, 0);
    chk_eq(req, "ss_reset", ss_reset, 1);
  endtask

  // Precharge pulse window after one cycle_start (R4).
  task automatic check_pc(input string req);
    cycle_start = 1'b1;
    @(negedge clk);
    cycle_start = 1'b0;
    for (int k = 0; k <= D + P + 1; k++) begin
      if (k > 0) @(negedge clk);
      chk_eq(req, "precharge ls_on", ls_on, (k >= D && k < D + P) ? 1 : 0);
      chk_eq(req, "precharge hs_on", hs_on, 0);
      chk_eq(req, "precharge ss_reset", ss_reset, 1);
    end
  endtask

  // Leave precharge with pwm high; first high-side pulse after 2D+M (R5, R9).
  task automatic go_run(input string req);
    uv_boot = 1'b0;
    pwm = 1'b1;
    cycle_start = 1'b1;
    @(negedge clk);
    cycle_start = 1'b0;
    chk_eq(req, "ss_reset after hand-over", ss_reset, 0);
    for (int k = 0; k <= 2 * D + M; k++) begin
      if (k > 0) @(negedge clk);
      chk_eq("R9", "ls_on before first hs", ls_on, 0);
      chk_eq(req, "first hs_on", hs_on, (k == 2 * D + M) ? 1 : 0);
    end
    @(negedge clk);
  endtask

  // One low pwm interval of L clocks in run mode (R8).
  task automatic pwm_low(input int L);
    int x;
    x = (L > D + M) ? L : D + M;
    pwm = 1'b0;
    for (int k = 0; k <= x + D + 1; k++) begin
      @(negedge clk);
      chk_eq("R8", $sformatf("hs_on L=%0d k=%0d", L, k), hs_on, (k >= x + D) ? 1 : 0);
      chk_eq("R8", $sformatf("ls_on L=%0d k=%0d", L, k), ls_on, (k >= D && k < x) ? 1 : 0);
      if (k == L - 1) pwm = 1'b1;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk_eq("R1", "reset hs_on", hs_on, 0);
    chk_eq("R1", "reset ls_on", ls_on, 0);
    chk_eq("R1", "reset ss_reset", ss_reset, 1);
    chk_eq("R1", "reset latched_off", latched_off, 0);

    // Start-up waits for the timing capacitor
    en = 1'b1;
    repeat (5) @(negedge clk);
    gates_off("R3");
    cycle_start = 1'b1;
    @(negedge clk);
    cycle_start = 1'b0;
    for (int k = 0; k < D + P + 2; k++) begin
      chk_eq("R3", "ls_on while waiting", ls_on, 0);
      @(negedge clk);
    end
    tcap_ready = 1'b1;
    repeat (2) @(negedge clk);
    check_pc("R4");
    check_pc("R4");

    // Pre-bias: run mode with pwm low must not drive the low side
    uv_boot = 1'b0;
    pwm = 1'b0;
    cycle_start = 1'b1;
    @(negedge clk);
    cycle_start = 1'b0;
    chk_eq("R5", "ss_reset released", ss_reset, 0);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      chk_eq("R9", "ls_on with no hs yet", ls_on, 0);
      chk_eq("R9", "hs_on with pwm low", hs_on, 0);
    end
    pwm = 1'b1;
    for (int k = 0; k <= D; k++) begin
      @(negedge clk);
      chk_eq("R9", "hs_on after pwm rise", hs_on, (k == D) ? 1 : 0);
      chk_eq("R9", "ls_on after pwm rise", ls_on, 0);
    end
    repeat (2) @(negedge clk);

    // Sweep the pwm low time
    for (int L = 1; L <= 9; L++) pwm_low(L);

    // Bootstrap undervoltage during run
    uv_boot = 1'b1;
    @(negedge clk);
    gates_off("R6");
    check_pc("R6");
    go_run("R5");

    // Hiccup
    hiccup_req = 1'b1;
    @(negedge clk);
    hiccup_req = 1'b0;
    gates_off("R7");
    repeat (5) @(negedge clk);
    gates_off("R7");
    uv_boot = 1'b1;
    hiccup_done = 1'b1;
    @(negedge clk);
    hiccup_done = 1'b0;
    check_pc("R7");
    go_run("R7");

    // Each rail and over-temperature, with automatic restart
    for (int i = 0; i <= NR; i++) begin
      if (i < NR) uv_rail[i] = 1'b1; else ot_flag = 1'b1;
      @(negedge clk);
      gates_off("R2");
      repeat (3) @(negedge clk);
      gates_off("R2");
      uv_boot = 1'b1;
      uv_rail = '0;
      ot_flag = 1'b0;
      repeat (2) @(negedge clk);
      check_pc("R2");
      go_run("R2");
    end

    // Rail fault release with the timing capacitor not ready
    uv_rail[0] = 1'b1;
    tcap_ready = 1'b0;
    @(negedge clk);
    gates_off("R3");
    uv_boot = 1'b1;
    uv_rail = '0;
    repeat (3) @(negedge clk);
    cycle_start = 1'b1;
    @(negedge clk);
    cycle_start = 1'b0;
    for (int k = 0; k < D + P + 2; k++) begin
      chk_eq("R3", "ls_on before tcap_ready", ls_on, 0);
      chk_eq("R3", "ss_reset before tcap_ready", ss_reset, 1);
      @(negedge clk);
    end
    tcap_ready = 1'b1;
    @(negedge clk);
    check_pc("R3");
    go_run("R3");

    // Standby from run
    en = 1'b0;
    @(negedge clk);
    gates_off("R1");
    chk_eq("R1", "standby latched_off", latched_off, 0);
    en = 1'b1;
    uv_boot = 1'b1;
    repeat (3) @(negedge clk);
    check_pc("R1");
    go_run("R1");

    // Shorted low-side gate
    pwm = 1'b0;
    short_inj = 1'b1;
    for (int k = 0; k <= D + M + 1; k++) begin
      @(negedge clk);
      chk_eq("R10", $sformatf("latched_off k=%0d", k), latched_off, (k >= D + M) ? 1 : 0);
      chk_eq("R10", $sformatf("ls_on k=%0d", k), ls_on, (k >= D && k < D + M) ? 1 : 0);
      if (k == 1) pwm = 1'b1;
    end
    for (int k = 0; k < 12; k++) begin
      pwm = k[1];
      cycle_start = (k == 5);
      @(negedge clk);
      chk_eq("R10", "latched hs_on", hs_on, 0);
      chk_eq("R10", "latched ls_on", ls_on, 0);
      chk_eq("R10", "latched_off held", latched_off, 1);
    end
    short_inj = 1'b0;
    uv_boot = 1'b0;
    repeat (3) @(negedge clk);
    chk_eq("R10", "latched_off after short clears", latched_off, 1);
    en = 1'b0;
    @(negedge clk);
    chk_eq("R10", "latched_off cleared by enable", latched_off, 0);
    gates_off("R1");

    chk_eq("R11", "cycles with both gates on", overlap_cnt, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule